// File: doc/BRIEF.md
# Sequential Phase-Frequency Detector

This block compares a line-rate reference pulse with the feedback pulse that a pixel-clock divider returns. It issues pump commands for a charge pump: raise, lower or idle. The two commands are never active together. The block also passes on a pump-gain selection and raises a lock flag once the loop has settled.

Both inputs are asynchronous to the system clock. Each one passes through a two-stage synchronizer and then an edge detector. The reference acts on its rising edge and the feedback acts on its falling edge. Each detected edge sets its own flag. When both flags are set, they clear together. The raise command is therefore as wide as the lead of the reference, counted in system clock cycles, and the lower command is as wide as its lag. Because the flags remember an edge until the other side answers, a frequency error gives a correction that lasts until the slower input catches up. The correction therefore always pushes the oscillator the right way.

Top module: `line_pfd`

## Requirements
- R1: Only a low-to-high transition of `ref_in` is acted on. A falling `ref_in` never starts a command.
- R2: Only a high-to-low transition of `fb_in` is acted on. A rising `fb_in` never starts a command.
- R3: `pump_up` and `pump_down` are never high in the same cycle. When both edges land in the same cycle, neither output pulses.
- R4: A reference edge that leads the feedback edge by N system cycles gives a `pump_up` pulse exactly N cycles wide. A reference edge that lags by N cycles gives a `pump_down` pulse N cycles wide. The output first rises in the third clock edge after the input changes.
- R5: Two reference edges with no feedback edge between them keep `pump_up` high without a break until the feedback edge arrives. The mirror case, two feedback edges with no reference edge, does the same for `pump_down`. After that, the detector is idle again.
- R6: The width of the high reference pulse and the width of the low feedback pulse do not change the command widths.
- R7: `pump_gain_hi` equals `gain_hi_in` as it was one clock earlier (1 = high pump current, 0 = low).
- R8: `locked` goes high after 8 comparisons in a row whose phase error (command width) is at most 2 cycles.
- R9: `locked` goes low, and the run count restarts, on any comparison whose error exceeds 2 cycles.
- R10: A synchronous active-high `rst` drops both commands and `locked` and returns the detector to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Line-rate reference, rising-edge active |
| fb_in | input | 1 | Divider feedback, falling-edge active |
| gain_hi_in | input | 1 | Pump gain select, 1 = high current |
| pump_up | output | 1 | Source-current command |
| pump_down | output | 1 | Sink-current command |
| pump_gain_hi | output | 1 | Registered gain select for the pump |
| locked | output | 1 | Loop settled indication |

## Verification
A flag that is stuck, or that fails to clear, appears at the ports within one comparison. The command width comes out wrong, or a command never ends, and the next zero-offset comparison then still shows pulses. An error in the edge polarity or in the synchronizer depth moves the first command cycle or lets an ignored transition start a command, both within three clocks. A fault in the run counter shows as `locked` rising one comparison early or late, or failing to drop on the first 3-cycle error.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_flags_t;

    typedef enum logic [1:0] {
        PUMP_IDLE = 2'b00,
        PUMP_DN   = 2'b01,
        PUMP_UP   = 2'b10
    } pump_cmd_t;

    // Only a single set flag drives the pump; both set is the masked overlap.
    function automatic pump_cmd_t flags_to_cmd(input pfd_flags_t f);
        case ({f.up, f.dn})
            2'b10:   return PUMP_UP;
            2'b01:   return PUMP_DN;
            default: return PUMP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES      = 2,
    parameter bit ACTIVE_RISE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_pulse
);
    localparam int LAST = STAGES - 1;

    // sh[0..LAST] synchronizer, sh[STAGES] previous synchronized value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    generate
        if (ACTIVE_RISE) begin : g_rise
            assign edge_pulse = sh[LAST] & ~sh[STAGES];
        end else begin : g_fall
            assign edge_pulse = ~sh[LAST] & sh[STAGES];
        end
    endgenerate

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |=> !edge_pulse); // R6

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_edge,
    input  logic       fb_edge,
    output pump_cmd_t  cmd,
    output logic       cmp_done
);
    pfd_flags_t flags;

    assign cmp_done = flags.up & flags.dn;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (cmp_done) begin
            // both answered: clear, but keep an edge landing in this cycle
            flags.up <= ref_edge;
            flags.dn <= fb_edge;
        end else begin
            flags.up <= flags.up | ref_edge;
            flags.dn <= flags.dn | fb_edge;
        end
    end

    assign cmd = flags_to_cmd(flags);

    AST_OVERLAP_SHORT: assert property (@(posedge clk) disable iff (rst)
        cmp_done |=> !cmp_done); // R3

    AST_UP_FROM_REF: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.up) |-> $past(ref_edge)); // R1

    AST_DN_FROM_FB: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.dn) |-> $past(fb_edge)); // R2

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
    parameter int TOL_CYCLES = 2,
    parameter int LOCK_COUNT = 8,
    parameter int ERR_W      = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic cmp_done,
    output logic locked
);
    localparam int RUN_W = $clog2(LOCK_COUNT + 1);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;
    localparam logic [ERR_W-1:0] TOL     = ERR_W'(TOL_CYCLES);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_COUNT);

    logic [ERR_W-1:0] err_cnt;
    logic [RUN_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_cnt <= '0;
            run_cnt <= '0;
        end else if (cmp_done) begin
            err_cnt <= '0;
            if (err_cnt <= TOL) begin
                if (run_cnt != RUN_TOP) run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
            end
        end else if (active) begin
            if (err_cnt != ERR_MAX) err_cnt <= err_cnt + 1'b1;
            if (err_cnt >= TOL)     run_cnt <= '0;
        end
    end

    assign locked = (run_cnt == RUN_TOP);

    AST_LOCK_AT_CMP: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(cmp_done)); // R8

    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
        (active && !cmp_done && err_cnt >= TOL) |=> !locked); // R9

endmodule

// File: rtl/line_pfd.sv
module line_pfd
    import pfd_pkg::*;
#(
    parameter int TOL_CYCLES = 2,
    parameter int LOCK_COUNT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fb_in,
    input  logic gain_hi_in,
    output logic pump_up,
    output logic pump_down,
    output logic pump_gain_hi,
    output logic locked
);
    logic      ref_edge;
    logic      fb_edge;
    logic      cmp_done;
    pump_cmd_t cmd;

    pfd_edge_sync #(.STAGES(SYNC_STAGES), .ACTIVE_RISE(1'b1)) u_ref_sync (
        .clk(clk), .rst(rst), .din(ref_in), .edge_pulse(ref_edge)
    );

    pfd_edge_sync #(.STAGES(SYNC_STAGES), .ACTIVE_RISE(1'b0)) u_fb_sync (
        .clk(clk), .rst(rst), .din(fb_in), .edge_pulse(fb_edge)
    );

    pfd_core u_core (
        .clk(clk), .rst(rst), .ref_edge(ref_edge), .fb_edge(fb_edge),
        .cmd(cmd), .cmp_done(cmp_done)
    );

    assign pump_up   = (cmd == PUMP_UP);
    assign pump_down = (cmd == PUMP_DN);

    always_ff @(posedge clk) begin
        if (rst) pump_gain_hi <= 1'b0;
        else     pump_gain_hi <= gain_hi_in;
    end

    pfd_lock_mon #(
        .TOL_CYCLES(TOL_CYCLES), .LOCK_COUNT(LOCK_COUNT), .ERR_W(4)
    ) u_lock (
        .clk(clk), .rst(rst), .active(pump_up | pump_down),
        .cmp_done(cmp_done), .locked(locked)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!pump_up && !pump_down && !locked)); // R10

endmodule

// File: tb/test_line_pfd.sv
module test_line_pfd;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b1;
    logic gain_hi_in = 1'b0;
    logic pump_up, pump_down, pump_gain_hi, locked;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int overlaps = 0;

    always #10 clk = ~clk;

    line_pfd i_line_pfd (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .gain_hi_in(gain_hi_in), .pump_up(pump_up), .pump_down(pump_down),
        .pump_gain_hi(pump_gain_hi), .locked(locked)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sample(inout int ups, inout int dns, inout int first_up, input int t);
        if (pump_up) begin
            ups++;
            if (first_up < 0) first_up = t;
        end
        if (pump_down) dns++;
        if (pump_up && pump_down) overlaps++;
    endtask

    // one comparison: ref rises at cycle 8, fb falls at cycle 8+d
    task automatic run_cmp(input int d, input int rh, input int fl,
                           output int ups, output int dns, output int first_up);
        int rs = 8;
        int fs = 8 + d;
        int tend = ((rs + rh > fs + fl) ? rs + rh : fs + fl) + 10;
        ups = 0; dns = 0; first_up = -1;
        for (int t = 0; t <= tend; t++) begin
            @(negedge clk);
            sample(ups, dns, first_up, t);
            ref_in = (t >= rs && t < rs + rh);
            fb_in  = !(t >= fs && t < fs + fl);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int u, dn, f;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 reset up", pump_up, 0);
        chk("R10 reset down", pump_down, 0);
        chk("R10 reset locked", locked, 0);

        // R4 sweep of phase offsets
        for (int d = -6; d <= 6; d++) begin
            run_cmp(d, 3, 3, u, dn, f);
            chk($sformatf("R4 up width d=%0d", d), u, (d > 0) ? d : 0);
            chk($sformatf("R4 down width d=%0d", d), dn, (d < 0) ? -d : 0);
            if (d == 0) chk("R3 coincident edges no pulse", u + dn, 0);
            if (d == 3) chk("R4 first up cycle", f, 11);
        end

        // R6 duty cycle sweep
        for (int rh = 1; rh <= 9; rh += 4)
            for (int fl = 1; fl <= 9; fl += 4) begin
                run_cmp(4, rh, fl, u, dn, f);
                chk($sformatf("R6 up rh=%0d fl=%0d", rh, fl), u, 4);
                run_cmp(-5, rh, fl, u, dn, f);
                chk($sformatf("R6 down rh=%0d fl=%0d", rh, fl), dn, 5);
            end

        // R1: ref falling alone starts nothing; R2: fb rising alone starts nothing
        begin
            int u1 = 0, d1 = 0, f1 = -1;
            ref_in = 1'b1;
            repeat (10) @(negedge clk);
            // now ref is high with its rise consumed? -> rise set up flag; pair it
            fb_in = 1'b0;
            repeat (6) @(negedge clk);
            fb_in = 1'b1; // rising fb: ignored
            for (int t = 0; t < 10; t++) begin
                @(negedge clk);
                sample(u1, d1, f1, t);
            end
            chk("R2 fb rise ignored", u1 + d1, 0);
            u1 = 0; d1 = 0;
            ref_in = 1'b0; // falling ref: ignored
            for (int t = 0; t < 10; t++) begin
                @(negedge clk);
                sample(u1, d1, f1, t);
            end
            chk("R1 ref fall ignored", u1 + d1, 0);
        end

        // R5 frequency error: two ref edges before fb
        begin
            int u2 = 0, d2 = 0, f2 = -1;
            for (int t = 0; t < 50; t++) begin
                @(negedge clk);
                sample(u2, d2, f2, t);
                ref_in = (t >= 8 && t < 11) || (t >= 28 && t < 31);
                fb_in  = !(t >= 38 && t < 41);
            end
            chk("R5 sustained up", u2, 30);
            chk("R5 no down while fast ref", d2, 0);
            u2 = 0; d2 = 0;
            for (int t = 0; t < 50; t++) begin
                @(negedge clk);
                sample(u2, d2, f2, t);
                fb_in  = !((t >= 8 && t < 11) || (t >= 28 && t < 31));
                ref_in = (t >= 38 && t < 41);
            end
            chk("R5 sustained down", d2, 30);
            chk("R5 no up while fast fb", u2, 0);
            run_cmp(0, 3, 3, u, dn, f);
            chk("R5 idle after recovery", u + dn, 0);
        end

        // R7 gain path
        @(negedge clk); gain_hi_in = 1'b1;
        @(negedge clk); chk("R7 gain high", pump_gain_hi, 1);
        gain_hi_in = 1'b0;
        @(negedge clk); chk("R7 gain low", pump_gain_hi, 0);

        // R8 / R9 lock behaviour
        do_reset();
        for (int n = 1; n <= 8; n++) begin
            run_cmp(0, 3, 3, u, dn, f);
            chk($sformatf("R8 lock after %0d", n), locked, (n == 8) ? 1 : 0);
        end
        run_cmp(2, 3, 3, u, dn, f);
        chk("R8 lock holds err 2", locked, 1);
        run_cmp(-2, 3, 3, u, dn, f);
        chk("R8 lock holds err -2", locked, 1);
        run_cmp(3, 3, 3, u, dn, f);
        chk("R9 lock drops err 3", locked, 0);
        for (int n = 1; n <= 8; n++) begin
            run_cmp(1, 3, 3, u, dn, f);
            chk($sformatf("R8 relock after %0d", n), locked, (n == 8) ? 1 : 0);
        end
        run_cmp(-3, 3, 3, u, dn, f);
        chk("R9 lock drops err -3", locked, 0);

        // R10 reset mid-command
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            ref_in = (t >= 1 && t < 3);
        end
        chk("R10 up active before reset", pump_up, 1);
        do_reset();
        chk("R10 up cleared", pump_up, 0);
        chk("R10 down cleared", pump_down, 0);
        run_cmp(0, 3, 3, u, dn, f);
        chk("R10 idle after reset", u + dn, 0);

        chk("R3 never both active", overlaps, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule